// File: doc/BRIEF.md
# Frequency-Select Watchdog with Safe Recovery

This block guards the frequency selection of a clock generator while software reprograms it. A down-counter is armed by software with a timeout in units of a slow tick (250 ms per tick, supplied by an external prescaler). If software does not stop or restart the counter before it runs out, the block assumes the new frequency hung the system. It then sets a sticky expiry flag and asks an open-drain pad to pull the system reset line low for a fixed number of ticks. At the same time it puts the frequency selection back to a known-good value.

The block also owns the selection path itself. The five frequency strap pins are captured once, when the power-good input rises. A software-select bit then chooses between that captured value and a code written by software. On expiry the recovery code is either a programmed safe code or the captured straps, depending on a safe-enable input. In both cases the M/N direct-programming mode is switched off, so the frequency table is in force again.

Top module: `wd_fsel_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, the outputs are: count = TMO_DEF (8), run = 0, expired = 0, reset request high (inactive), fsel = 0, mn_mode = 0.
- R2: The strap value is captured in the clock edge where pwr_good_i is seen high after being low. Changes on strap_fs_i at any other time do not alter fsel_o while software select is off.
- R3: fsel_o equals the stored software code when the stored select bit is 1, and the captured strap value when it is 0. A sw_wr_i pulse loads code, select bit and M/N bit in one edge.
- R4: When wd_en_i is seen high after being low, the count is loaded from tmo_val_i, run becomes 1 and the expired flag clears, all in the same edge.
- R5: While running and enabled, each tick_i cycle lowers the count by one. With no tick the count holds.
- R6: A tick that finds the count at 1 or 0 while running ends the run: count 0, run 0, expired 1. A timeout value of 0 therefore expires on the first tick. The expired flag stays set until the next restart.
- R7: wd_rst_n_o goes low in the expiry edge and stays low for RST_TICKS further ticks (default 1). It returns high in the edge of the last of those ticks.
- R8: On expiry with safe_en_i = 1, the software code becomes safe_code_i and the select bit becomes 1.
- R9: On expiry with safe_en_i = 0, the select bit becomes 0, so fsel_o shows the captured straps.
- R10: On expiry the M/N mode output clears, even if a sw_wr_i pulse arrives in the same cycle. Expiry has priority over the write.
- R11: While wd_en_i is low, run is 0, ticks have no effect and the count follows tmo_val_i one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 250 ms timebase step |
| pwr_good_i | input | 1 | Power-good level; rising edge captures straps |
| strap_fs_i | input | 5 | Frequency strap pins |
| sw_wr_i | input | 1 | Write strobe for the software selection fields |
| sw_code_i | input | 5 | Software frequency code |
| sw_sel_i | input | 1 | 1 = use software code, 0 = use straps |
| sw_mn_i | input | 1 | M/N direct-programming mode request |
| safe_en_i | input | 1 | Recover to safe code (1) or straps (0) on expiry |
| safe_code_i | input | 5 | Safe frequency code |
| tmo_val_i | input | 8 | Timeout in ticks |
| wd_en_i | input | 1 | Watchdog enable; rising edge restarts |
| wd_count_o | output | 8 | Current count |
| wd_run_o | output | 1 | 1 while the counter is running |
| wd_expired_o | output | 1 | Sticky expiry flag |
| wd_rst_n_o | output | 1 | Active-low reset request for an open-drain pad |
| fsel_o | output | 5 | Active frequency selection |
| mn_mode_o | output | 1 | M/N direct-programming mode active |

## Verification
Every result is registered once, so each input is due exactly one clock edge after the cycle that presents it. Restart, decrement and expiry, the reset request, the selection change and the M/N clear all appear together in that edge. The only delay is the release of the reset request, which waits for RST_TICKS further tick cycles. The bench drives inputs just after a falling edge and keeps a behavioural model that it advances on each rising edge. It compares all outputs against that model at the next falling edge, so every comparison falls one edge after its stimulus. Directed checks sample at the same point.

// File: rtl/wd_fsel_pkg.sv
// Shared definitions for the frequency-select watchdog.
// Assumes a five-bit frequency code throughout.
package wd_fsel_pkg;
    localparam int FS_W = 5;

    // Software-controlled selection state
    typedef struct packed {
        logic            sel;
        logic            mn;
        logic [FS_W-1:0] code;
    } sw_sel_t;
endpackage

// File: rtl/wd_strap_latch.sv
// Captures the strap pins on the rising edge of power-good.
// Assumes pwr_good_i is already synchronous to clk.
module wd_strap_latch
    import wd_fsel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwr_good_i,
    input  logic [FS_W-1:0] strap_i,
    output logic [FS_W-1:0] strap_q_o
);
    logic pg_q;

    // Track power-good and capture the straps on its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q      <= 1'b0;
            strap_q_o <= '0;
        end else begin
            pg_q <= pwr_good_i;
            if (pwr_good_i && !pg_q)
                strap_q_o <= strap_i;
        end
    end
endmodule

// File: rtl/wd_countdown.sv
// Watchdog down-counter. It restarts on a rising enable and counts ticks.
// It raises a one-cycle expire strobe when a tick finds the count at 1 or 0.
// Assumes tick_i is a single-cycle pulse.
module wd_countdown #(
    parameter int TMO_W   = 8,
    parameter int TMO_DEF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic [TMO_W-1:0] cnt_o,
    output logic             run_o,
    output logic             expired_o,
    output logic             expire_o
);
    logic en_q;
    logic restart;

    assign restart  = en_i && !en_q;
    assign expire_o = en_i && !restart && run_o && tick_i && (cnt_o <= TMO_W'(1));

    // Counter, run and sticky expiry state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            cnt_o     <= TMO_W'(TMO_DEF);
            run_o     <= 1'b0;
            expired_o <= 1'b0;
        end else begin
            en_q <= en_i;
            if (restart) begin
                cnt_o     <= tmo_i;
                run_o     <= 1'b1;
                expired_o <= 1'b0;
            end else if (!en_i) begin
                cnt_o <= tmo_i;
                run_o <= 1'b0;
            end else if (expire_o) begin
                cnt_o     <= '0;
                run_o     <= 1'b0;
                expired_o <= 1'b1;
            end else if (run_o && tick_i) begin
                cnt_o <= cnt_o - TMO_W'(1);
            end
        end
    end
endmodule

// File: rtl/wd_rst_pulse.sv
// Stretches the expire strobe into a reset request lasting a number of ticks.
// The output is active low and meant to drive an open-drain pad.
module wd_rst_pulse #(
    parameter int RST_TICKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic fire_i,
    output logic rst_n_o
);
    localparam int PC_W = $clog2(RST_TICKS + 1);

    logic [PC_W-1:0] left;

    // Load on fire, count down on ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (fire_i)
            left <= PC_W'(RST_TICKS);
        else if (tick_i && left != '0)
            left <= left - PC_W'(1);
    end

    assign rst_n_o = (left == '0);
endmodule

// File: rtl/wd_fsel_top.sv
// Frequency-select watchdog top. It joins the strap capture, the countdown,
// the reset stretcher and the software selection registers.
// On expiry it forces recovery of the frequency selection.
// Assumes all inputs are synchronous to clk.
module wd_fsel_top
    import wd_fsel_pkg::*;
#(
    parameter int TMO_W     = 8,
    parameter int TMO_DEF   = 8,
    parameter int RST_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             pwr_good_i,
    input  logic [FS_W-1:0]  strap_fs_i,
    input  logic             sw_wr_i,
    input  logic [FS_W-1:0]  sw_code_i,
    input  logic             sw_sel_i,
    input  logic             sw_mn_i,
    input  logic             safe_en_i,
    input  logic [FS_W-1:0]  safe_code_i,
    input  logic [TMO_W-1:0] tmo_val_i,
    input  logic             wd_en_i,
    output logic [TMO_W-1:0] wd_count_o,
    output logic             wd_run_o,
    output logic             wd_expired_o,
    output logic             wd_rst_n_o,
    output logic [FS_W-1:0]  fsel_o,
    output logic             mn_mode_o
);
    logic [FS_W-1:0] strap_q;
    logic            expire;
    sw_sel_t         sw_q;

    wd_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good_i (pwr_good_i),
        .strap_i    (strap_fs_i),
        .strap_q_o  (strap_q)
    );

    wd_countdown #(.TMO_W(TMO_W), .TMO_DEF(TMO_DEF)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .en_i      (wd_en_i),
        .tmo_i     (tmo_val_i),
        .cnt_o     (wd_count_o),
        .run_o     (wd_run_o),
        .expired_o (wd_expired_o),
        .expire_o  (expire)
    );

    wd_rst_pulse #(.RST_TICKS(RST_TICKS)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .fire_i  (expire),
        .rst_n_o (wd_rst_n_o)
    );

    // Software selection registers; expiry recovery has priority over writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else if (expire) begin
            sw_q.mn <= 1'b0;
            if (safe_en_i) begin
                sw_q.code <= safe_code_i;
                sw_q.sel  <= 1'b1;
            end else begin
                sw_q.sel  <= 1'b0;
            end
        end else if (sw_wr_i) begin
            sw_q.code <= sw_code_i;
            sw_q.sel  <= sw_sel_i;
            sw_q.mn   <= sw_mn_i;
        end
    end

    // Source mux between software code and captured straps
    assign fsel_o    = sw_q.sel ? sw_q.code : strap_q;
    assign mn_mode_o = sw_q.mn;
endmodule

// File: rtl/wd_fsel_chk.sv
// Property checker for wd_fsel_top, attached by bind. It observes ports only.
module wd_fsel_chk
    import wd_fsel_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             safe_en_i,
    input logic [FS_W-1:0]  safe_code_i,
    input logic [TMO_W-1:0] tmo_val_i,
    input logic             wd_en_i,
    input logic [TMO_W-1:0] wd_count_o,
    input logic             wd_run_o,
    input logic             wd_expired_o,
    input logic             wd_rst_n_o,
    input logic [FS_W-1:0]  fsel_o,
    input logic             mn_mode_o
);
    // R4: start of a run loads the timeout and clears the flag
    p_restart_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_run_o) |-> (!wd_expired_o && wd_count_o == $past(tmo_val_i)));

    // R5: a running counter drops by one per tick
    p_tick_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_run_o && $past(wd_run_o) && $past(tick_i)) |-> wd_count_o == $past(wd_count_o) - TMO_W'(1));

    // R5: without a tick the running count holds
    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_run_o && $past(wd_run_o) && !$past(tick_i)) |-> $stable(wd_count_o));

    // R6: a run that ends while enabled ends in expiry at zero
    p_end_is_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wd_run_o) && $past(wd_en_i) && wd_en_i) |-> (wd_expired_o && wd_count_o == '0));

    // R7: expiry brings the reset request low
    p_rst_on_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired_o) |-> !wd_rst_n_o);

    // R8: safe recovery selects the safe code
    p_safe_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(wd_expired_o) && $past(safe_en_i)) |-> fsel_o == $past(safe_code_i));

    // R10: expiry clears M/N mode
    p_mn_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_expired_o) |-> !mn_mode_o);

    // R11: disabled watchdog does not run
    p_idle_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wd_en_i) |-> !wd_run_o);
endmodule

bind wd_fsel_top wd_fsel_chk #(.TMO_W(TMO_W)) u_wd_fsel_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .safe_en_i    (safe_en_i),
    .safe_code_i  (safe_code_i),
    .tmo_val_i    (tmo_val_i),
    .wd_en_i      (wd_en_i),
    .wd_count_o   (wd_count_o),
    .wd_run_o     (wd_run_o),
    .wd_expired_o (wd_expired_o),
    .wd_rst_n_o   (wd_rst_n_o),
    .fsel_o       (fsel_o),
    .mn_mode_o    (mn_mode_o)
);

// File: tb/wd_fsel_top_tb_top.sv
`timescale 1ns/1ps
// Bench for wd_fsel_top: a behavioural model checked every cycle, plus directed checks.
module wd_fsel_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, pwr_good_i = 1'b0, sw_wr_i = 1'b0, sw_sel_i = 1'b0, sw_mn_i = 1'b0;
    logic       safe_en_i = 1'b0, wd_en_i = 1'b0;
    logic [4:0] strap_fs_i = '0, sw_code_i = '0, safe_code_i = '0;
    logic [7:0] tmo_val_i = 8'd8;
    logic [7:0] wd_count_o;
    logic       wd_run_o, wd_expired_o, wd_rst_n_o, mn_mode_o;
    logic [4:0] fsel_o;

    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    // Model state
    int m_cnt = 8, m_pc = 0, m_strap = 0, m_code = 0;
    bit m_run = 0, m_exp = 0, m_enq = 0, m_pgq = 0, m_sel = 0, m_mn = 0;

    always #2.5 clk = ~clk;

    wd_fsel_top dut_i (.*);

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model on each rising edge
    always @(posedge clk) begin
        bit fire;
        if (!rst_n) begin
            m_cnt = 8; m_run = 0; m_exp = 0; m_enq = 0; m_pc = 0;
            m_strap = 0; m_pgq = 0; m_code = 0; m_sel = 0; m_mn = 0;
        end else begin
            fire = wd_en_i && m_enq && m_run && tick_i && m_cnt <= 1;
            if (pwr_good_i && !m_pgq) m_strap = strap_fs_i;
            m_pgq = pwr_good_i;
            if (fire) begin
                m_mn = 0;
                if (safe_en_i) begin m_code = safe_code_i; m_sel = 1; end
                else m_sel = 0;
            end else if (sw_wr_i) begin
                m_code = sw_code_i; m_sel = sw_sel_i; m_mn = sw_mn_i;
            end
            if (fire) m_pc = 1;
            else if (tick_i && m_pc > 0) m_pc--;
            if (wd_en_i && !m_enq) begin m_cnt = tmo_val_i; m_run = 1; m_exp = 0; end
            else if (!wd_en_i) begin m_cnt = tmo_val_i; m_run = 0; end
            else if (fire) begin m_cnt = 0; m_run = 0; m_exp = 1; end
            else if (m_run && tick_i) m_cnt--;
            m_enq = wd_en_i;
        end
    end

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            chk(wd_count_o, m_cnt, "R5 count");
            chk(wd_run_o, m_run, "R5 run");
            chk(wd_expired_o, m_exp, "R6 expired");
            chk(wd_rst_n_o, m_pc == 0, "R7 reset request");
            chk(fsel_o, m_sel ? m_code : m_strap, "R3 fsel");
            chk(mn_mode_o, m_mn, "R10 mn mode");
        end
    end

    // Watchdog against a hung run
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
        #0.5;
    endtask

    task automatic tick();
        tick_i = 1'b1; step(); tick_i = 1'b0;
    endtask

    task automatic swr(input int code, input bit sel, input bit mn);
        sw_code_i = code[4:0]; sw_sel_i = sel; sw_mn_i = mn; sw_wr_i = 1'b1;
        step(); sw_wr_i = 1'b0;
    endtask

    initial begin
        step(3);
        // R1 reset values
        chk(wd_count_o, 8, "R1 count"); chk(wd_run_o, 0, "R1 run");
        chk(wd_expired_o, 0, "R1 expired"); chk(wd_rst_n_o, 1, "R1 rst");
        chk(fsel_o, 0, "R1 fsel"); chk(mn_mode_o, 0, "R1 mn");
        rst_n = 1'b1; step();
        chk(wd_count_o, 8, "R1 count after release");
        // R2 strap capture and ignore afterwards
        strap_fs_i = 5'h16; pwr_good_i = 1'b1; step();
        chk(fsel_o, 5'h16, "R2 capture");
        strap_fs_i = 5'h01; step(2);
        chk(fsel_o, 5'h16, "R2 straps ignored");
        // R3 source select
        swr(5'h0A, 1, 1);
        chk(fsel_o, 5'h0A, "R3 sw code"); chk(mn_mode_o, 1, "R3 mn");
        swr(5'h0A, 0, 1);
        chk(fsel_o, 5'h16, "R3 straps");
        // R4, R5, R6, R7, R8, R10: safe recovery
        swr(5'h0A, 1, 1);
        tmo_val_i = 8'd3; safe_en_i = 1'b1; safe_code_i = 5'h1F;
        wd_en_i = 1'b1; step();
        chk(wd_count_o, 3, "R4 reload"); chk(wd_run_o, 1, "R4 run");
        step(2);
        chk(wd_count_o, 3, "R5 hold without tick");
        tick(); chk(wd_count_o, 2, "R5 dec");
        tick(); chk(wd_count_o, 1, "R5 dec");
        tick();
        chk(wd_expired_o, 1, "R6 expiry"); chk(wd_run_o, 0, "R6 stop");
        chk(wd_rst_n_o, 0, "R7 low"); chk(fsel_o, 5'h1F, "R8 safe code");
        chk(mn_mode_o, 0, "R10 mn cleared");
        step(3); chk(wd_rst_n_o, 0, "R7 held until tick");
        tick(); chk(wd_rst_n_o, 1, "R7 release");
        chk(wd_expired_o, 1, "R6 sticky");
        // R11 disable, R9 strap recovery with timeout 0
        wd_en_i = 1'b0; tmo_val_i = 8'd0; step();
        chk(wd_run_o, 0, "R11 off"); chk(wd_count_o, 0, "R11 mirror");
        safe_en_i = 1'b0; swr(5'h03, 1, 1);
        wd_en_i = 1'b1; step();
        chk(wd_expired_o, 0, "R4 flag cleared"); chk(wd_run_o, 1, "R4 run");
        tick();
        chk(wd_expired_o, 1, "R6 zero expires"); chk(fsel_o, 5'h16, "R9 straps");
        tick();
        // R11 ticks ignored while disabled
        wd_en_i = 1'b0; tmo_val_i = 8'd5; step();
        wd_en_i = 1'b1; step(); tick(); tick();
        wd_en_i = 1'b0; step();
        tick(); tick(); tick(); tick(); tick();
        chk(wd_run_o, 0, "R11 no run"); chk(wd_count_o, 5, "R11 count");
        chk(wd_rst_n_o, 1, "R11 no reset");
        // R10 expiry beats same-cycle write
        tmo_val_i = 8'd1; wd_en_i = 1'b1; step();
        sw_code_i = 5'h07; sw_sel_i = 1'b1; sw_mn_i = 1'b1; sw_wr_i = 1'b1; tick_i = 1'b1;
        step(); sw_wr_i = 1'b0; tick_i = 1'b0;
        chk(mn_mode_o, 0, "R10 priority"); chk(fsel_o, 5'h16, "R10 priority fsel");
        tick(); step(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule